// File: doc/BRIEF.md
# Dual-Modulus Swallow Divider

This block is the main feedback divider of a frequency synthesizer. It divides its input clock by N = P·B + A. The structure is a dual-modulus prescaler model that divides by P+1 or by P, followed by a swallow counter (A) and a main counter (B). In each division period the prescaler first spends A of its own cycles at modulus P+1. It then spends the remaining B−A cycles at modulus P. The base modulus P is picked by a 2-bit code. The prescaler is modelled digitally and runs on the same clock as the counters.

The divider produces one single-cycle pulse per period. A, B and the prescaler code are sampled only at the end of a period, or while a reset is applied, so a running period is never corrupted. A counter-hold input keeps both counters at their start values so that the divider restarts in step with an external reference. If the A/B setting that is in use is illegal, the block raises a flag and keeps its pulse output low.

Top module: `swallow_divider`

## Requirements
- R1: With a legal setting, the first `div_out` pulse is visible N clock edges after the last edge that sampled a reset or hold, and later pulses repeat every N edges, with N = P·B + A.
- R2: The prescaler code `psel` selects the base modulus P as follows: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64.
- R3: `a_set` is 6 bits (0..63) and `b_set` is 13 bits (0..8191). A setting is legal exactly when B ≥ 3 and A ≤ B. The legal extremes A = 0, A = B and B = 3 divide correctly.
- R4: While the setting in use is illegal, `bad_cfg` is 1 and `div_out` stays 0. `bad_cfg` is 0 for a legal setting.
- R5: Each `div_out` pulse lasts exactly one clock cycle.
- R6: A new A, B or `psel` applied during a period does not change that period. It takes effect from the following period on, and this also holds when the new value replaces an illegal setting.
- R7: While `cnt_rst` is 1, no pulse is produced and both counters stay at their start values. Counting restarts when `cnt_rst` returns to 0.
- R8: While `rst` is 1, `div_out` is 0, and the inputs present are loaded as the setting in use.
- R9: Within a period, the prescaler runs at P+1 for the first A prescaler cycles and at P for the rest. The period therefore exceeds P·B by exactly A, which distinguishes A = 0 from A = B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| cnt_rst | input | 1 | Counter hold, active high, synchronous |
| a_set | input | 6 | Swallow count A |
| b_set | input | 13 | Main count B |
| psel | input | 2 | Prescaler modulus code |
| div_out | output | 1 | One-cycle pulse per division period |
| bad_cfg | output | 1 | Setting in use is illegal |

## Verification
The setting in use is registered at the edge that samples a reset, a hold or the end of a period. For this reason `bad_cfg` is checked half a cycle after that edge, and the first pulse is expected N edges later. The bench counts falling edges from the release of a reset or hold and requires the pulse at exactly count N. It then checks that the output is low one cycle later and that the next pulse arrives after N−1 more cycles. For a change made in the middle of a period, the bench expects the old length to finish first and the new length to apply after it. When an illegal setting is replaced, counting starts at the falling edge where `bad_cfg` first reads 0, and the first pulse is expected N edges after that point.

// File: rtl/swd_pkg.sv
package swd_pkg;
  // Base prescaler modulus: 2^(base_log2 + code)
  function automatic int presc_base(int base_log2, int code);
    return 1 << (base_log2 + code);
  endfunction

  // Legal swallow setting: main count at least 3, swallow not above main
  function automatic bit cfg_legal(int a, int b);
    return (b >= 3) && (a <= b);
  endfunction
endpackage

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 3,
  parameter int PC_W      = BASE_LOG2 + (1 << SEL_W)
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             hi_mod,
  input  logic [SEL_W-1:0] sel,
  output logic             pre_end,
  output logic [PC_W-1:0]  pc_o
);
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] base;
  logic [PC_W-1:0] last;

  always_comb begin
    base    = PC_W'(swd_pkg::presc_base(BASE_LOG2, int'(sel)));
    last    = hi_mod ? base : base - 1'b1;
    pre_end = (pc == last);
  end

  always_ff @(posedge clk) begin
    if (clear || pre_end) pc <= '0;
    else                  pc <= pc + 1'b1;
  end

  assign pc_o = pc;
endmodule

// File: rtl/swd_swallow.sv
module swd_swallow #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           load,
  input  logic           pre_end,
  input  logic [A_W-1:0] ld_a,
  input  logic [B_W-1:0] ld_b,
  output logic           hi_mod,
  output logic           term
);
  logic [A_W-1:0] a_left;
  logic [B_W-1:0] b_left;

  always_comb begin
    hi_mod = (a_left != '0);
    term   = pre_end && (b_left <= B_W'(1));
  end

  always_ff @(posedge clk) begin
    if (load || term) begin
      a_left <= ld_a;
      b_left <= ld_b;
    end else if (pre_end) begin
      if (a_left != '0) a_left <= a_left - 1'b1;
      b_left <= b_left - 1'b1;
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int A_W       = 6,
  parameter int B_W       = 13,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_rst,
  input  logic [A_W-1:0]   a_set,
  input  logic [B_W-1:0]   b_set,
  input  logic [SEL_W-1:0] psel,
  output logic             div_out,
  output logic             bad_cfg
);
  localparam int PC_W = BASE_LOG2 + (1 << SEL_W);

  logic             load;
  logic             reload;
  logic             term;
  logic             hi_mod;
  logic             pre_end;
  logic [PC_W-1:0]  pc;
  logic [A_W-1:0]   cfg_a;
  logic [B_W-1:0]   cfg_b;
  logic [SEL_W-1:0] cfg_p;
  logic             cfg_ok;

  assign load   = rst || cnt_rst;
  assign reload = load || term;

  // Setting in use: captured only at reset, hold or period end
  always_ff @(posedge clk) begin
    if (reload) begin
      cfg_a <= a_set;
      cfg_b <= b_set;
      cfg_p <= psel;
    end
  end

  assign cfg_ok  = swd_pkg::cfg_legal(int'(cfg_a), int'(cfg_b));
  assign bad_cfg = !cfg_ok;

  swd_prescaler #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .PC_W(PC_W)) u_pre (
    .clk     (clk),
    .clear   (load),
    .hi_mod  (hi_mod),
    .sel     (cfg_p),
    .pre_end (pre_end),
    .pc_o    (pc)
  );

  swd_swallow #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk     (clk),
    .load    (load),
    .pre_end (pre_end),
    .ld_a    (a_set),
    .ld_b    (b_set),
    .hi_mod  (hi_mod),
    .term    (term)
  );

  always_ff @(posedge clk) begin
    if (load) div_out <= 1'b0;
    else      div_out <= term && cfg_ok;
  end
endmodule

// File: rtl/swd_chk.sv
module swd_chk #(
  parameter int A_W       = 6,
  parameter int B_W       = 13,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 3,
  parameter int PC_W      = BASE_LOG2 + (1 << SEL_W)
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_rst,
  input logic             div_out,
  input logic             bad_cfg,
  input logic             reload,
  input logic             hi_mod,
  input logic [PC_W-1:0]  pc,
  input logic [A_W-1:0]   cfg_a,
  input logic [B_W-1:0]   cfg_b,
  input logic [SEL_W-1:0] cfg_p
);
  bit armed;
  bit live;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
    live <= armed;
  end

  a_r5_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> !div_out);

  a_r7_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    cnt_rst |=> !div_out);

  a_r4_bad_gates_output: assert property (@(posedge clk) disable iff (rst || !armed)
    bad_cfg |=> !div_out);

  a_r6_cfg_steady: assert property (@(posedge clk) disable iff (rst || !armed)
    !reload |=> ($stable(cfg_a) && $stable(cfg_b) && $stable(cfg_p)));

  a_r9_slow_phase_entry: assert property (@(posedge clk) disable iff (rst || !live)
    $rose(hi_mod) |-> $past(reload));

  a_r2_pc_bound: assert property (@(posedge clk) disable iff (rst || !armed)
    pc <= PC_W'(swd_pkg::presc_base(BASE_LOG2, int'(cfg_p))));
endmodule

bind swallow_divider swd_chk #(
  .A_W(A_W), .B_W(B_W), .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cnt_rst (cnt_rst),
  .div_out (div_out),
  .bad_cfg (bad_cfg),
  .reload  (reload),
  .hi_mod  (hi_mod),
  .pc      (pc),
  .cfg_a   (cfg_a),
  .cfg_b   (cfg_b),
  .cfg_p   (cfg_p)
);

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        cnt_rst = 1'b0;
  logic [5:0]  a_set = '0;
  logic [12:0] b_set = 13'd3;
  logic [1:0]  psel = '0;
  logic        div_out;
  logic        bad_cfg;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  swallow_divider u_dut (
    .clk(clk), .rst(rst), .cnt_rst(cnt_rst), .a_set(a_set), .b_set(b_set),
    .psel(psel), .div_out(div_out), .bad_cfg(bad_cfg)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Base modulus from code: 8, 16, 32, 64 (R2)
  function automatic int len_of(int a, int b, int p);
    int base;
    base = 8;
    for (int i = 0; i < p; i++) base = base * 2;
    return base * b + a;
  endfunction

  task automatic set_cfg(int a, int b, int p);
    a_set = 6'(a);
    b_set = 13'(b);
    psel  = 2'(p);
  endtask

  task automatic do_reset(int a, int b, int p);
    @(negedge clk);
    set_cfg(a, b, p);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Count falling edges until div_out reads 1; -1 if limit reached
  task automatic wait_pulse(int limit, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!div_out && k < limit);
    if (!div_out) k = -1;
  endtask

  task automatic run_legal(int a, int b, int p);
    int n, k;
    n = len_of(a, b, p);
    do_reset(a, b, p);
    chk(bad_cfg == 1'b0, "R3 legal setting not flagged", int'(bad_cfg), 0);
    wait_pulse(n + 5, k);
    chk(k == n, "R1 R2 R9 first pulse position", k, n);
    @(negedge clk);
    chk(div_out == 1'b0, "R5 pulse width", int'(div_out), 0);
    wait_pulse(n + 5, k);
    chk(k + 1 == n, "R1 period between pulses", k + 1, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k, k2, cnt;
    int bl[3] = '{3, 5, 11};

    // R8: reset state
    @(negedge clk);
    rst = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(div_out == 1'b0, "R8 output low in reset", int'(div_out), 0);
    end
    rst = 1'b0;

    // R1 R2 R3 R9 sweep
    for (int p = 0; p < 4; p++)
      for (int bi = 0; bi < 3; bi++) begin
        run_legal(0, bl[bi], p);
        run_legal(1, bl[bi], p);
        run_legal(bl[bi] / 2, bl[bi], p);
        run_legal(bl[bi], bl[bi], p);
      end
    run_legal(63, 63, 0);
    run_legal(63, 100, 1);

    // R4: illegal settings (A > B, B < 3)
    do_reset(4, 3, 0);
    chk(bad_cfg == 1'b1, "R4 A above B flagged", int'(bad_cfg), 1);
    do_reset(0, 2, 1);
    chk(bad_cfg == 1'b1, "R4 B below 3 flagged", int'(bad_cfg), 1);
    do_reset(5, 3, 0);
    chk(bad_cfg == 1'b1, "R4 A=5 B=3 flagged", int'(bad_cfg), 1);
    cnt = 0;
    repeat (300) begin
      @(negedge clk);
      if (div_out) cnt++;
    end
    chk(cnt == 0, "R4 no pulse while illegal", cnt, 0);

    // R6: legal setting replaces illegal one at a period end
    set_cfg(0, 3, 0);
    k = 0;
    while (bad_cfg && k < 100) begin
      @(negedge clk);
      k++;
      chk(div_out == 1'b0, "R4 no pulse before recovery", int'(div_out), 0);
    end
    chk(bad_cfg == 1'b0, "R6 illegal replaced at period end", int'(bad_cfg), 0);
    wait_pulse(40, k);
    chk(k == 24, "R6 first pulse after recovery", k, 24);

    // R6: change in mid period
    do_reset(0, 3, 0);
    repeat (10) @(negedge clk);
    set_cfg(1, 4, 1);
    wait_pulse(100, k);
    chk(k + 10 == 24, "R6 running period keeps old length", k + 10, 24);
    @(negedge clk);
    chk(div_out == 1'b0, "R5 pulse width after change", int'(div_out), 0);
    wait_pulse(100, k2);
    chk(k2 + 1 == 65, "R6 new length from next period", k2 + 1, 65);

    // R7: counter hold
    do_reset(2, 3, 0);
    repeat (10) @(negedge clk);
    cnt_rst = 1'b1;
    cnt = 0;
    repeat (60) begin
      @(negedge clk);
      if (div_out) cnt++;
    end
    chk(cnt == 0, "R7 no pulse during hold", cnt, 0);
    cnt_rst = 1'b0;
    wait_pulse(60, k);
    chk(k == 26, "R7 restart aligned after hold", k, 26);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule